// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns a 32-bit virtual address into a physical address. It first looks the virtual page number up in a small fully associative translation cache. On a hit it answers at once. On a miss it walks a two-level page table held in memory, fetching one entry per level through a simple request/acknowledge read port.

The walk starts from a base address supplied on an input. A length input bounds how many outer-table entries exist. An entry whose valid bit is clear ends the walk with a page-fault response. That response carries the faulting virtual address and a cause code.

Requests are accepted one at a time through a valid/ready handshake. Each request produces exactly one single-cycle response. A flush input empties the translation cache, and software must pulse it whenever the table base changes.

Top module: `xl_translate`

## Requirements
- R1: A virtual address is split into an outer index (bits 31:22), an inner index (bits 21:12) and an offset (bits 11:0). A successful translation returns the 20-bit frame from the inner entry, joined with the unchanged 12-bit offset.
- R2: The outer entry is read at byte address base + 4 × outer index. The inner entry is read at byte address {outer entry bits 31:12, 12'h000} + 4 × inner index. The address on the read port stays stable while a read waits for its acknowledge.
- R3: When the outer index is greater than or equal to the length input, the block responds with a fault of cause 1 (length) and issues no memory read.
- R4: An outer entry with bit 0 clear gives a fault of cause 2 after exactly one memory read. Every fault response has rsp_fault high, rsp_paddr zero and a non-zero cause.
- R5: An inner entry with bit 0 clear gives a fault of cause 3 after exactly two memory reads. A successful walk also takes exactly two reads and reports cause 0.
- R6: A request whose virtual page number is held valid in the translation cache is answered with the cached frame and no memory read.
- R7: A faulting walk never fills the cache, so repeating a faulting request performs the same reads again.
- R8: The cache holds 8 entries. Each successful walk writes the entry at a replacement pointer that advances by one and wraps, so the ninth distinct fill after an empty cache evicts the first.
- R9: A flush clears every cache entry and returns the replacement pointer to entry 0, so the next request for any page walks the table.
- R10: rsp_valid is high for exactly one cycle per accepted request, with rsp_vaddr equal to the request address. req_ready is low from the cycle after acceptance until the response.
- R11: Bits 11:1 of every table entry are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Byte address of the outer table |
| tbl_len | input | 11 | Number of outer-table entries |
| flush | input | 1 | Invalidate all cache entries |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Table entry: bits 31:12 base/frame, bit 0 valid |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_cause | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_vaddr | output | 32 | Virtual address of this response |

## Verification
The bench sweeps outer indices from 0 past the length bound, each with inner indices at both ends of their range and in between. Because the table contents depend on both indices, this separates length faults, outer-invalid and inner-invalid faults, and good walks, and a swapped or misplaced index field shows up as a wrong frame or read address. Every address is issued twice in a row, which tells a cache hit (no reads) apart from a repeated fault walk. Table entries carry noise in bits 11:1 to expose any use of ignored bits. Two further passes follow: a run of nine distinct pages exposes the replacement order, and a flush between repeats shows that the cache is cleared.

// File: rtl/xl_pkg.sv
package xl_pkg;
   typedef enum logic [1:0] {
      CZ_NONE  = 2'd0,
      CZ_LEN   = 2'd1,
      CZ_OUTER = 2'd2,
      CZ_INNER = 2'd3
   } cause_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CHK  = 2'd1,
      ST_OUT  = 2'd2,
      ST_IN   = 2'd3
   } wstate_t;
endpackage

// File: rtl/xl_tcache.sv
module xl_tcache #(
   parameter int VPN_W = 20,
   parameter int FRM_W = 20,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [FRM_W-1:0] hit_frm,
   input  logic             fill,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [FRM_W-1:0] fill_frm
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << IDX_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("xl_tcache: DEPTH must be a power of two, at least 2");
   end

   logic [DEPTH-1:0] vld;
   logic [VPN_W-1:0] tag [DEPTH];
   logic [FRM_W-1:0] frm [DEPTH];
   logic [IDX_W-1:0] ptr;
   logic [DEPTH-1:0] match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld[g] && (tag[g] == look_vpn);
   end

   always_comb begin
      hit     = |match;
      hit_frm = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match[i]) hit_frm = hit_frm | frm[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld <= '0;
         ptr <= '0;
      end else if (fill) begin
         vld[ptr] <= 1'b1;
         ptr      <= ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill && !flush) begin
         tag[ptr] <= fill_vpn;
         frm[ptr] <= fill_frm;
      end
   end
endmodule

// File: rtl/xl_walk.sv
module xl_walk
   import xl_pkg::*;
#(
   parameter int P1_W  = 10,
   parameter int P2_W  = 10,
   parameter int OFF_W = 12,
   parameter int PA_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic [PA_W-1:0]       tbl_base,
   input  logic [P1_W:0]         tbl_len,
   output logic [P1_W+P2_W-1:0]  c_vpn,
   input  logic                  c_hit,
   input  logic [PA_W-OFF_W-1:0] c_frm,
   output logic                  fill,
   output logic [PA_W-OFF_W-1:0] fill_frm,
   output logic                  mem_req,
   output logic [PA_W-1:0]       mem_addr,
   input  logic                  mem_ack,
   input  logic [PA_W-1:0]       mem_rdata,
   output logic                  rsp_valid,
   output logic                  rsp_fault,
   output logic [1:0]            rsp_cause,
   output logic [PA_W-1:0]       rsp_paddr,
   output logic [VA_W-1:0]       rsp_vaddr
);
   localparam int VA_W  = P1_W + P2_W + OFF_W;
   localparam int FRM_W = PA_W - OFF_W;

   wstate_t         st_q;
   logic [VA_W-1:0] va_q;
   logic [FRM_W-1:0] obase_q;

   logic [P1_W-1:0]  p1;
   logic [P2_W-1:0]  p2;
   logic [OFF_W-1:0] off;
   logic             ent_ok;
   logic [FRM_W-1:0] ent_frm;

   assign p1      = va_q[VA_W-1 -: P1_W];
   assign p2      = va_q[OFF_W +: P2_W];
   assign off     = va_q[OFF_W-1:0];
   assign c_vpn   = va_q[VA_W-1:OFF_W];
   assign ent_ok  = mem_rdata[0];
   assign ent_frm = mem_rdata[PA_W-1:OFF_W];

   assign req_ready = (st_q == ST_IDLE);
   assign mem_req   = (st_q == ST_OUT) || (st_q == ST_IN);
   assign mem_addr  = (st_q == ST_OUT)
                    ? tbl_base + PA_W'({p1, 2'b00})
                    : {obase_q, {OFF_W{1'b0}}} + PA_W'({p2, 2'b00});
   assign fill      = (st_q == ST_IN) && mem_ack && ent_ok;
   assign fill_frm  = ent_frm;
   assign rsp_vaddr = va_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         obase_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_cause <= CZ_NONE;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q <= req_vaddr;
               st_q <= ST_CHK;
            end
            ST_CHK: begin
               if (c_hit) begin
                  rsp_valid <= 1'b1; rsp_fault <= 1'b0; rsp_cause <= CZ_NONE;
                  rsp_paddr <= {c_frm, off};
                  st_q      <= ST_IDLE;
               end else if ({1'b0, p1} >= tbl_len) begin
                  rsp_valid <= 1'b1; rsp_fault <= 1'b1; rsp_cause <= CZ_LEN;
                  rsp_paddr <= '0;
                  st_q      <= ST_IDLE;
               end else begin
                  st_q <= ST_OUT;
               end
            end
            ST_OUT: if (mem_ack) begin
               if (!ent_ok) begin
                  rsp_valid <= 1'b1; rsp_fault <= 1'b1; rsp_cause <= CZ_OUTER;
                  rsp_paddr <= '0;
                  st_q      <= ST_IDLE;
               end else begin
                  obase_q <= ent_frm;
                  st_q    <= ST_IN;
               end
            end
            ST_IN: if (mem_ack) begin
               rsp_valid <= 1'b1;
               st_q      <= ST_IDLE;
               if (!ent_ok) begin
                  rsp_fault <= 1'b1; rsp_cause <= CZ_INNER; rsp_paddr <= '0;
               end else begin
                  rsp_fault <= 1'b0; rsp_cause <= CZ_NONE; rsp_paddr <= {ent_frm, off};
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xl_translate.sv
module xl_translate #(
   parameter int P1_W     = 10,
   parameter int P2_W     = 10,
   parameter int OFF_W    = 12,
   parameter int PA_W     = 32,
   parameter int TC_DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [P1_W+P2_W+OFF_W-1:0]   req_vaddr,
   input  logic [PA_W-1:0]              tbl_base,
   input  logic [P1_W:0]                tbl_len,
   input  logic                         flush,
   output logic                         mem_req,
   output logic [PA_W-1:0]              mem_addr,
   input  logic                         mem_ack,
   input  logic [PA_W-1:0]              mem_rdata,
   output logic                         rsp_valid,
   output logic                         rsp_fault,
   output logic [1:0]                   rsp_cause,
   output logic [PA_W-1:0]              rsp_paddr,
   output logic [P1_W+P2_W+OFF_W-1:0]   rsp_vaddr
);
   localparam int VPN_W = P1_W + P2_W;
   localparam int FRM_W = PA_W - OFF_W;

   if (PA_W <= OFF_W || PA_W < P1_W + 2 || PA_W < P2_W + 2) begin : g_bad_width
      $error("xl_translate: physical width too small for the index or offset fields");
   end

   logic [VPN_W-1:0] c_vpn;
   logic             c_hit;
   logic [FRM_W-1:0] c_frm;
   logic             fill;
   logic [FRM_W-1:0] fill_frm;

   xl_tcache #(.VPN_W(VPN_W), .FRM_W(FRM_W), .DEPTH(TC_DEPTH)) u_tc (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .look_vpn(c_vpn), .hit(c_hit), .hit_frm(c_frm),
      .fill(fill), .fill_vpn(c_vpn), .fill_frm(fill_frm)
   );

   xl_walk #(.P1_W(P1_W), .P2_W(P2_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .tbl_base(tbl_base), .tbl_len(tbl_len),
      .c_vpn(c_vpn), .c_hit(c_hit), .c_frm(c_frm),
      .fill(fill), .fill_frm(fill_frm),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
   );
endmodule

// File: rtl/xl_translate_chk.sv
module xl_translate_chk #(
   parameter int P1_W  = 10,
   parameter int P2_W  = 10,
   parameter int OFF_W = 12,
   parameter int PA_W  = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic                       req_ready,
   input logic [P1_W:0]              tbl_len,
   input logic                       mem_req,
   input logic [PA_W-1:0]            mem_addr,
   input logic                       mem_ack,
   input logic                       rsp_valid,
   input logic                       rsp_fault,
   input logic [1:0]                 rsp_cause,
   input logic [PA_W-1:0]            rsp_paddr,
   input logic [P1_W+P2_W+OFF_W-1:0] rsp_vaddr
);
   localparam int VA_W = P1_W + P2_W + OFF_W;

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]); // R1
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2
   AST_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_cause == 2'd1 |-> {1'b0, rsp_vaddr[VA_W-1 -: P1_W]} >= tbl_len); // R3
   AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_cause != 2'd0 && rsp_paddr == '0); // R4
   AST_OK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_cause == 2'd0); // R5
   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req); // R6
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R10
endmodule

bind xl_translate xl_translate_chk #(.P1_W(P1_W), .P2_W(P2_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .tbl_len(tbl_len), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
   .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
   .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
);

// File: tb/xl_translate_bench.sv
`timescale 1ns/1ps
module xl_translate_bench;
   localparam logic [31:0] BASE = 32'h0010_0000;
   localparam int          LEN  = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] tbl_base = BASE;
   logic [10:0] tbl_len = 11'(LEN);
   logic        flush = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid, rsp_fault;
   logic [1:0]  rsp_cause;
   logic [31:0] rsp_paddr, rsp_vaddr;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int nreads = 0;
   logic [31:0] raddr [2];

   int cvpn [8];
   bit cval [8];
   int cptr = 0;

   always #4 clk = ~clk;

   xl_translate u_xl_translate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .tbl_base(tbl_base), .tbl_len(tbl_len), .flush(flush),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
   );

   function automatic bit outer_ok(int p1);
      return (p1 % 5) != 3;
   endfunction
   function automatic bit inner_ok(int p1, int p2);
      return ((p1 + p2) % 7) != 6;
   endfunction
   function automatic logic [19:0] frame_of(int p1, int p2);
      return 20'((p1 * 37 + p2 * 11 + 5) & 32'hFFFFF);
   endfunction
   function automatic logic [31:0] inner_tbl(int p1);
      return {20'h40000 | 20'(p1), 12'h000};
   endfunction
   // table image: noise in bits 11:1 (R11)
   function automatic logic [31:0] mem_model(logic [31:0] a);
      int p1, p2;
      if (a[31:12] == BASE[31:12]) begin
         p1 = int'(a[11:2]);
         return {inner_tbl(p1)[31:12], 11'h2A5, outer_ok(p1)};
      end else if (a[31:22] == 10'h100) begin
         p1 = int'(a[21:12]);
         p2 = int'(a[11:2]);
         return {frame_of(p1, p2), 11'h3C3, inner_ok(p1, p2)};
      end
      return 32'h0;
   endfunction

   task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // memory responder: acknowledge one cycle after a request is seen
   initial forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
         if (nreads < 2) raddr[nreads] = mem_addr;
         nreads++;
         mem_rdata = mem_model(mem_addr);
         mem_ack = 1'b1;
      end else begin
         mem_ack = 1'b0;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic xlate(logic [31:0] va, string ctx);
      int p1, p2, exp_reads, t;
      bit hit, exp_fault;
      logic [1:0] exp_cause;
      logic [31:0] exp_pa;
      p1 = int'(va[31:22]);
      p2 = int'(va[21:12]);
      hit = 1'b0;
      for (int i = 0; i < 8; i++) if (cval[i] && cvpn[i] == int'(va[31:12])) hit = 1'b1;
      exp_pa = '0; exp_fault = 1'b1; exp_reads = 0;
      if (hit) begin
         exp_fault = 1'b0; exp_cause = 2'd0; exp_pa = {frame_of(p1, p2), va[11:0]};
      end else if (p1 >= LEN) begin
         exp_cause = 2'd1;
      end else if (!outer_ok(p1)) begin
         exp_cause = 2'd2; exp_reads = 1;
      end else if (!inner_ok(p1, p2)) begin
         exp_cause = 2'd3; exp_reads = 2;
      end else begin
         exp_fault = 1'b0; exp_cause = 2'd0; exp_reads = 2;
         exp_pa = {frame_of(p1, p2), va[11:0]};
         cvpn[cptr] = int'(va[31:12]); cval[cptr] = 1'b1; cptr = (cptr + 1) % 8;
      end
      nreads = 0;
      @(negedge clk);
      chk(req_ready == 1'b1, {"R10 ready before request ", ctx}, 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {"R10 busy after accept ", ctx}, 32'(req_ready), 32'd0);
      t = 0;
      while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
      chk(rsp_valid == 1'b1, {"R10 response seen ", ctx}, 32'(rsp_valid), 32'd1);
      chk(rsp_vaddr == va, {"R10 rsp_vaddr ", ctx}, rsp_vaddr, va);
      chk(rsp_fault == exp_fault, {"R3 R4 R5 fault flag ", ctx}, 32'(rsp_fault), 32'(exp_fault));
      chk(rsp_cause == exp_cause, {"R3 R4 R5 cause ", ctx}, 32'(rsp_cause), 32'(exp_cause));
      chk(rsp_paddr == exp_pa, {"R1 R6 R11 paddr ", ctx}, rsp_paddr, exp_pa);
      chk(nreads == exp_reads, {"R3 R4 R5 R6 R7 read count ", ctx}, 32'(nreads), 32'(exp_reads));
      if (exp_reads >= 1)
         chk(raddr[0] == BASE + 32'(p1 * 4), {"R2 outer address ", ctx}, raddr[0], BASE + 32'(p1 * 4));
      if (exp_reads == 2)
         chk(raddr[1] == inner_tbl(p1) + 32'(p2 * 4), {"R2 R11 inner address ", ctx},
             raddr[1], inner_tbl(p1) + 32'(p2 * 4));
      @(negedge clk);
      chk(rsp_valid == 1'b0, {"R10 single-cycle response ", ctx}, 32'(rsp_valid), 32'd0);
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      for (int i = 0; i < 8; i++) cval[i] = 1'b0;
      cptr = 0;
   endtask

   initial begin
      logic [31:0] va;
      for (int i = 0; i < 8; i++) begin cval[i] = 1'b0; cvpn[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
      chk(rsp_valid == 1'b0, "R10 reset no response", 32'(rsp_valid), 32'd0);
      chk(mem_req == 1'b0, "R6 reset no read", 32'(mem_req), 32'd0);

      // sweep outer index past the length bound, several inner patterns, each twice
      for (int p1 = 0; p1 < 16; p1++) begin
         for (int k = 0; k < 4; k++) begin
            int p2;
            p2 = (k == 0) ? 0 : (k == 1) ? 1023 : (k == 2) ? (p1 * 3) : (p1 + 5);
            va = {10'(p1), 10'(p2), 12'((p1 * k * 97) & 12'hFFF)};
            xlate(va, "sweep first");
            xlate(va, "sweep repeat R6 R7");
         end
      end

      // replacement order
      do_flush();
      for (int p2 = 0; p2 < 10; p2++) xlate({10'd0, 10'(p2), 12'h123}, "R8 fill");
      xlate({10'd0, 10'd0, 12'h456}, "R8 evicted entry");
      xlate({10'd0, 10'd2, 12'h789}, "R8 kept entry");
      xlate({10'd0, 10'd1, 12'h00A}, "R8 second eviction");

      // flush empties the cache
      xlate({10'd1, 10'd4, 12'hABC}, "R9 prime");
      xlate({10'd1, 10'd4, 12'hABC}, "R9 hit before flush");
      do_flush();
      xlate({10'd1, 10'd4, 12'hABD}, "R9 walk after flush");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule